// File: doc/BRIEF.md
# PHY Reset and Power-State Controller

This block decides when the rest of a transceiver-style device is held in reset, when its transmitter may drive the line and when its functions are powered. A raw active-low reset pin is qualified by a short run of low samples and then stretched by a long down-counter. During the stretch the management output is tri-stated and register reads return all ones. A self-clearing control bit starts a fixed-length software reset. Both kinds of reset load the device configuration from strap inputs.

A supply-fault indicator and a power-down request each pass through a two-flop synchronizer. A supply fault closes the transmit gate and shows up in a status bit that follows the present condition. Power-down removes the function enable but leaves the management registers readable, writable and intact. A parallel register port (address, write strobe, read strobe, data) stands in for the serial management framing, which sits outside this block.

Top module: `phy_rst_pwr_ctl`

## Requirements
- R1: A hardware reset is accepted only when `rst_pin_n` is sampled low on at least QUAL_CYC (default 2) consecutive clock edges. `core_rst` rises three edges after the pin is first driven low. A pin that is low on a single edge has no effect.
- R2: After the pin is released, the internal reset is held for STRETCH_CYC = CLK_KHZ*STRETCH_US/1000 more cycles, and `core_rst` falls STRETCH_CYC+2 edges after the release. A reset that qualifies again during the stretch reloads the full count.
- R3: While the hardware reset is held, `mdo_oe` is 0 and every register read returns all ones.
- R4: Writing register address 0 with bit 15 set starts a software reset of SW_SEQ_CYC cycles. Bit 15 of address 0 reads 1 for those cycles and then 0 by itself, and `core_rst` is 1 meanwhile.
- R5: Both the hardware reset and the software reset load bits [STRAP_W-1:0] of address 0 (also driven on `cfg_out`) from `strap_in` and clear bits [14:STRAP_W]. A write made during a software reset is overwritten by this reload.
- R6: While the synchronized `supply_low` is 1, `tx_en` is 0 and bit 2 of address 20 reads 1. Both follow the input three edges after it changes and recover without any other action.
- R7: While the synchronized `pdn_req` is 1, `func_en` and `tx_en` are 0, `mdo_oe` stays 1, registers stay accessible, and their contents are kept after power-down ends.
- R8: Address 0 reads {software-reset busy, bits [14:0] as last written or loaded}. Address 20 reads the fault flag in bit 2 and zeros elsewhere. Every other address reads 0. Read data appears on the edge that samples `mg_rd`.
- R9: The synchronous `rst` input behaves as a hardware reset with a full stretch. `core_rst` is 1 and `tx_en`, `func_en` and `mdo_oe` are 0 from the first edge, and `core_rst` falls STRETCH_CYC+1 edges after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | Raw hardware reset pin, active low |
| pdn_req | input | 1 | Power-down request, asynchronous |
| supply_low | input | 1 | Low-supply indicator, asynchronous |
| strap_in | input | STRAP_W | Strap configuration inputs |
| mg_wr | input | 1 | Register write strobe |
| mg_rd | input | 1 | Register read strobe |
| mg_addr | input | ADDR_W | Register address |
| mg_wdata | input | DATA_W | Register write data |
| mg_rdata | output | DATA_W | Register read data |
| core_rst | output | 1 | Internal reset to the rest of the device |
| tx_en | output | 1 | Transmit output gate |
| func_en | output | 1 | Function enable, low in reset or power-down |
| mdo_oe | output | 1 | Management data output enable |
| cfg_out | output | STRAP_W | Active configuration |

## Verification
Each result has a fixed delay after its stimulus. `core_rst` and `mdo_oe` change three edges after the pin is driven low, and STRETCH_CYC+2 edges after it is released. `tx_en` and `func_en` follow `supply_low` and `pdn_req` by three edges. A read returns, on its sampling edge, the state present when the strobe was raised. The bench drives every input one time unit after a rising edge and samples one time unit after a later edge. It counts edges so that each check lands on the last cycle before a transition and on the first cycle after it. The random supply-fault sweep compares `tx_en` against a three-deep history of the values driven.

// File: rtl/prc_pkg.sv
package prc_pkg;
  // Register addresses and bit positions decoded by management software
  parameter int unsigned CTRL_ADDR = 0;
  parameter int unsigned FLT_ADDR  = 20;
  parameter int unsigned SWRST_BIT = 15;
  parameter int unsigned FAULT_BIT = 2;
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/prc_rst_qual.sv
module prc_rst_qual #(
  parameter int unsigned QUAL_CYC    = 2,
  parameter int unsigned STRETCH_CYC = 75000
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hold
);
  localparam int unsigned QW = $clog2(QUAL_CYC + 1);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);

  logic [QW-1:0] low_run, low_run_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          qual_now, qual_d, hold_q;

  assign qual_now = (low_run == QW'(QUAL_CYC));

  always_comb begin
    if (pin_n)                         low_run_d = '0;
    else if (low_run == QW'(QUAL_CYC)) low_run_d = low_run;
    else                               low_run_d = low_run + QW'(1);
    qual_d = (low_run_d == QW'(QUAL_CYC));
    // Reload while qualified; count down once the pin is released
    if (qual_now)         cnt_d = CW'(STRETCH_CYC);
    else if (cnt != '0)   cnt_d = cnt - CW'(1);
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      cnt     <= CW'(STRETCH_CYC);
      hold_q  <= 1'b1;
    end else begin
      low_run <= low_run_d;
      cnt     <= cnt_d;
      hold_q  <= qual_d | (cnt_d != '0);
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/prc_swrst.sv
module prc_swrst #(
  parameter int unsigned SEQ_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int unsigned SW = $clog2(SEQ_CYC + 1);

  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= SW'(SEQ_CYC);
    else if (cnt != '0)   cnt <= cnt - SW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/prc_regs.sv
module prc_regs
  import prc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned STRAP_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               blocked,
  input  logic               sw_busy,
  input  logic               fault,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [STRAP_W-1:0] cfg,
  output logic               start
);
  logic [DATA_W-1:0] ctl_q, word, busy_word;
  logic              wr_ok, hit_ctrl, hit_flt;

  assign wr_ok    = wr & ~blocked;
  assign hit_ctrl = (addr == ADDR_W'(CTRL_ADDR));
  assign hit_flt  = (addr == ADDR_W'(FLT_ADDR));
  assign start    = wr_ok & hit_ctrl & wdata[SWRST_BIT];

  // Control word storage; the self-clearing bit position is never stored
  always_ff @(posedge clk) begin
    if (rst)                             ctl_q <= '0;
    else if (blocked | sw_busy | start)  ctl_q <= DATA_W'(strap);
    else if (wr_ok & hit_ctrl)           ctl_q <= wdata & ~(DATA_W'(1) << SWRST_BIT);
  end

  always_comb begin
    busy_word = DATA_W'(sw_busy) << SWRST_BIT;
    word      = '0;
    if (hit_ctrl)     word = (ctl_q & ~(DATA_W'(1) << SWRST_BIT)) | busy_word;
    else if (hit_flt) word[FAULT_BIT] = fault;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= blocked ? '1 : word;
  end

  assign cfg = ctl_q[STRAP_W-1:0];
endmodule

// File: rtl/phy_rst_pwr_ctl.sv
module phy_rst_pwr_ctl
  import prc_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned STRETCH_US  = 300,
  parameter int unsigned QUAL_CYC    = 2,
  parameter int unsigned SW_SEQ_CYC  = 16,
  parameter int unsigned STRAP_W     = 5,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_pin_n,
  input  logic               pdn_req,
  input  logic               supply_low,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               mg_wr,
  input  logic               mg_rd,
  input  logic [ADDR_W-1:0]  mg_addr,
  input  logic [DATA_W-1:0]  mg_wdata,
  output logic [DATA_W-1:0]  mg_rdata,
  output logic               core_rst,
  output logic               tx_en,
  output logic               func_en,
  output logic               mdo_oe,
  output logic [STRAP_W-1:0] cfg_out
);
  localparam int unsigned STRETCH_CYC = CLK_KHZ * STRETCH_US / 1000;

  logic [1:0] sync_q;
  logic       pdn_s, low_s;
  logic       hw_hold, sw_busy, sw_start;

  prc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pdn_req, supply_low}), .q(sync_q)
  );
  assign pdn_s = sync_q[1];
  assign low_s = sync_q[0];

  prc_rst_qual #(.QUAL_CYC(QUAL_CYC), .STRETCH_CYC(STRETCH_CYC)) u_qual (
    .clk(clk), .rst(rst), .pin_n(rst_pin_n), .hold(hw_hold)
  );

  prc_swrst #(.SEQ_CYC(SW_SEQ_CYC)) u_swrst (
    .clk(clk), .rst(rst), .start(sw_start), .busy(sw_busy)
  );

  prc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRAP_W(STRAP_W)) u_regs (
    .clk(clk), .rst(rst), .blocked(hw_hold), .sw_busy(sw_busy),
    .fault(low_s), .strap(strap_in), .wr(mg_wr), .rd(mg_rd),
    .addr(mg_addr), .wdata(mg_wdata), .rdata(mg_rdata),
    .cfg(cfg_out), .start(sw_start)
  );

  // Registered gates toward the rest of the device
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rst <= 1'b1;
      tx_en    <= 1'b0;
      func_en  <= 1'b0;
      mdo_oe   <= 1'b0;
    end else begin
      core_rst <= hw_hold | sw_busy;
      tx_en    <= ~(hw_hold | sw_busy | low_s | pdn_s);
      func_en  <= ~(hw_hold | sw_busy | pdn_s);
      mdo_oe   <= ~hw_hold;
    end
  end
endmodule

// File: rtl/prc_chk.sv
module prc_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rst_pin_n,
  input logic              hold,
  input logic              sw_busy,
  input logic              sw_start,
  input logic              low_s,
  input logic              pdn_s,
  input logic              mg_rd,
  input logic [DATA_W-1:0] mg_rdata,
  input logic              core_rst,
  input logic              tx_en,
  input logic              func_en,
  input logic              mdo_oe
);
  AST_QUAL_TWO_LOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> (!$past(rst_pin_n) && !$past(rst_pin_n, 2))); // R1

  AST_HOLD_ENDS_PIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> $past(rst_pin_n)); // R2

  AST_MDO_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold |=> !mdo_oe); // R3

  AST_READ_ONES_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mg_rd && hold) |=> (&mg_rdata)); // R3

  AST_SW_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_busy) |-> $past(sw_start)); // R4

  AST_SW_BUSY_RESETS_CORE: assert property (@(posedge clk) disable iff (rst)
    sw_busy |=> core_rst); // R4

  AST_TX_GATED_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    low_s |=> !tx_en); // R6

  AST_FUNC_OFF_IN_PDN: assert property (@(posedge clk) disable iff (rst)
    pdn_s |=> (!func_en && mdo_oe == !$past(hold))); // R7
endmodule

bind phy_rst_pwr_ctl prc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .hold(hw_hold),
  .sw_busy(sw_busy), .sw_start(sw_start), .low_s(low_s), .pdn_s(pdn_s),
  .mg_rd(mg_rd), .mg_rdata(mg_rdata), .core_rst(core_rst),
  .tx_en(tx_en), .func_en(func_en), .mdo_oe(mdo_oe)
);

// File: tb/phy_rst_pwr_ctl_bench.sv
`timescale 1ns/1ps
module phy_rst_pwr_ctl_bench;
  localparam int KHZ = 250000;
  localparam int US  = 2;
  localparam int S   = KHZ * US / 1000;
  localparam int SWC = 16;
  localparam int SW  = 5;

  logic          clk = 1'b0;
  logic          rst, rst_pin_n, pdn_req, supply_low, mg_wr, mg_rd;
  logic [SW-1:0] strap_in;
  logic [4:0]    mg_addr;
  logic [15:0]   mg_wdata, mg_rdata;
  logic          core_rst, tx_en, func_en, mdo_oe;
  logic [SW-1:0] cfg_out;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  phy_rst_pwr_ctl #(.CLK_KHZ(KHZ), .STRETCH_US(US), .SW_SEQ_CYC(SWC),
                    .STRAP_W(SW)) u_phy_rst_pwr_ctl (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .pdn_req(pdn_req),
    .supply_low(supply_low), .strap_in(strap_in), .mg_wr(mg_wr),
    .mg_rd(mg_rd), .mg_addr(mg_addr), .mg_wdata(mg_wdata),
    .mg_rdata(mg_rdata), .core_rst(core_rst), .tx_en(tx_en),
    .func_en(func_en), .mdo_oe(mdo_oe), .cfg_out(cfg_out)
  );

  function automatic logic [15:0] ctrl_word(input logic busy, input logic [15:0] stored);
    return {busy, stored[14:0]};
  endfunction

  function automatic logic [15:0] stat_word(input logic fault);
    logic [15:0] w = '0;
    w[2] = fault;
    return w;
  endfunction

  function automatic logic [15:0] map_word(input logic [4:0] a, input logic [15:0] stored);
    if (a == 5'd0)  return ctrl_word(1'b0, stored);
    if (a == 5'd20) return stat_word(1'b0);
    return 16'h0000;
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mwrite(input logic [4:0] a, input logic [15:0] d);
    mg_wr = 1'b1; mg_addr = a; mg_wdata = d;
    tick;
    mg_wr = 1'b0;
  endtask

  task automatic mread(input logic [4:0] a, output logic [15:0] d);
    mg_rd = 1'b1; mg_addr = a;
    tick;
    mg_rd = 1'b0;
    d = mg_rdata;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      summary;
    end
  end

  initial begin
    logic [15:0] r;
    logic [2:0]  h;
    int unsigned seed_dummy;
    rst = 1'b1; rst_pin_n = 1'b1; pdn_req = 1'b0; supply_low = 1'b0;
    strap_in = 5'h13; mg_wr = 1'b0; mg_rd = 1'b0; mg_addr = '0; mg_wdata = '0;
    seed_dummy = $urandom(32'd20240);

    // R9: power-on reset state and full stretch
    repeat (3) tick;
    chk("R9 core_rst in rst", core_rst, 1);
    chk("R9 tx_en in rst", tx_en, 0);
    chk("R9 func_en in rst", func_en, 0);
    chk("R9 mdo_oe in rst", mdo_oe, 0);
    rst = 1'b0;
    repeat (S) tick;
    chk("R9 core_rst last stretch cycle", core_rst, 1);
    tick;
    chk("R9 core_rst released", core_rst, 0);
    chk("R9 mdo_oe released", mdo_oe, 1);
    chk("R9 tx_en released", tx_en, 1);
    chk("R9 func_en released", func_en, 1);
    chk("R5 cfg from strap after power-on", cfg_out, 5'h13);

    // R8: register map
    mread(5'd0, r);
    chk("R8 ctrl after reset", r, ctrl_word(0, 16'h0013));
    mwrite(5'd0, 16'h7FEA);
    mread(5'd0, r);
    chk("R8 ctrl readback", r, ctrl_word(0, 16'h7FEA));
    chk("R8 cfg_out follows write", cfg_out, 5'h0A);
    mread(5'd20, r);
    chk("R8 status no fault", r, stat_word(0));
    mread(5'd7, r);
    chk("R8 unmapped address", r, 16'h0000);

    // R4/R5: software reset, self-clearing, strap reload
    strap_in = 5'h06;
    mwrite(5'd0, 16'h8011);
    chk("R4 core_rst not yet", core_rst, 0);
    mread(5'd0, r);
    chk("R4 busy bit reads 1", r, ctrl_word(1, 16'h0006));
    chk("R4 core_rst during sw reset", core_rst, 1);
    chk("R4 tx_en off during sw reset", tx_en, 0);
    mwrite(5'd0, 16'h001F);
    mread(5'd0, r);
    chk("R5 write lost during sw reset", r, ctrl_word(1, 16'h0006));
    repeat (SWC - 4) tick;
    mread(5'd0, r);
    chk("R4 busy last cycle", r, ctrl_word(1, 16'h0006));
    chk("R4 core_rst still high", core_rst, 1);
    mread(5'd0, r);
    chk("R4 busy self-cleared", r, ctrl_word(0, 16'h0006));
    chk("R4 core_rst dropped", core_rst, 0);
    chk("R5 cfg_out from strap", cfg_out, 5'h06);

    // R1: single low sample ignored
    rst_pin_n = 1'b0; tick; rst_pin_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick;
      chk("R1 glitch ignored", core_rst, 0);
    end

    // R1/R2/R3: qualified hardware reset with requalify during stretch
    mwrite(5'd0, 16'h0003);
    strap_in = 5'h0C;
    rst_pin_n = 1'b0;
    tick; tick;
    chk("R1 core_rst not before third edge", core_rst, 0);
    tick;
    chk("R1 core_rst on third edge", core_rst, 1);
    chk("R3 mdo_oe off", mdo_oe, 0);
    mread(5'd0, r);
    chk("R3 read returns ones", r, 16'hFFFF);
    strap_in = 5'h19;
    rst_pin_n = 1'b1;
    repeat (S / 2) tick;
    chk("R2 still held mid stretch", core_rst, 1);
    rst_pin_n = 1'b0; tick; tick; rst_pin_n = 1'b1;
    repeat (S + 1) tick;
    chk("R2 reloaded stretch still held", core_rst, 1);
    chk("R3 mdo_oe still off", mdo_oe, 0);
    tick;
    chk("R2 stretch ended", core_rst, 0);
    chk("R3 mdo_oe back on", mdo_oe, 1);
    chk("R5 cfg_out from strap after hw reset", cfg_out, 5'h19);
    mread(5'd0, r);
    chk("R5 ctrl after hw reset", r, ctrl_word(0, 16'h0019));

    // R6: supply fault gate and status
    supply_low = 1'b1;
    tick; tick;
    chk("R6 tx_en before sync", tx_en, 1);
    tick;
    chk("R6 tx_en gated", tx_en, 0);
    mread(5'd20, r);
    chk("R6 fault bit set", r, stat_word(1));
    supply_low = 1'b0;
    repeat (3) tick;
    chk("R6 tx_en recovered", tx_en, 1);
    mread(5'd20, r);
    chk("R6 fault bit cleared", r, stat_word(0));

    // R6: random supply-fault sweep
    h = '0;
    for (int i = 0; i < 300; i++) begin
      logic v;
      v = ($urandom() % 3) == 0;
      supply_low = v;
      h = {h[1:0], v};
      tick;
      if (i >= 2) chk("R6 random tx_en", tx_en, !h[2]);
    end
    supply_low = 1'b0;
    repeat (3) tick;

    // R8: random register writes and reads
    for (int i = 0; i < 30; i++) begin
      logic [15:0] w;
      logic [4:0]  a;
      w = 16'($urandom()) & 16'h7FFF;
      mwrite(5'd0, w);
      mread(5'd0, r);
      chk("R8 random ctrl readback", r, ctrl_word(0, w));
      chk("R8 random cfg_out", cfg_out, w[4:0]);
      a = 5'($urandom());
      mread(a, r);
      chk("R8 random address map", r, map_word(a, w));
    end

    // R7: power-down keeps registers and management access
    mwrite(5'd0, 16'h0015);
    pdn_req = 1'b1;
    tick; tick;
    chk("R7 func_en before sync", func_en, 1);
    tick;
    chk("R7 func_en off", func_en, 0);
    chk("R7 tx_en off", tx_en, 0);
    chk("R7 mdo_oe stays on", mdo_oe, 1);
    chk("R7 no core reset", core_rst, 0);
    mread(5'd0, r);
    chk("R7 registers kept", r, ctrl_word(0, 16'h0015));
    mwrite(5'd0, 16'h000E);
    mread(5'd0, r);
    chk("R7 write during power-down", r, ctrl_word(0, 16'h000E));
    pdn_req = 1'b0;
    repeat (3) tick;
    chk("R7 func_en back", func_en, 1);
    chk("R7 tx_en back", tx_en, 1);
    chk("R7 cfg kept after power-down", cfg_out, 5'h0E);

    done = 1;
    summary;
  end
endmodule